// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This unit collects the interrupt causes of a serial port and condenses them into a single packed 32-bit status word, an interrupt line and a readable configuration word. There are five causes: received data has reached its trigger level, a character timeout has occurred, there is room in the transmit buffer, a line error has been latched, and a modem input has changed. Bit 0 of the status word is a pending flag that is low while any enabled cause is active. The three bits above it name the cause with the highest priority.

The FIFO and serial logic deliver the causes as one-cycle pulses, or as levels for transmit space. Software sees two strobes. A status read clears the latched line errors and the modem change flags. A receive acknowledge, issued once received data has been consumed, clears the receive-data and timeout causes. The configuration word stores the four cause enables and six modem-control output bits. All other bits of that word read as zero.

All inputs pass through one register stage. A pulse or level applied before a clock edge is therefore visible on the status word and on `irq` from that edge onward.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the status word reads 32'h0000FF01 when all source inputs are low, the configuration word reads 0 and `irq` is low.
- R2: Status bit 0 is low exactly when an enabled cause is pending, and `irq` is always its inverse.
- R3: Status bits 3:1 carry the cause code: 0 modem change, 1 transmit space, 2 receive data, 3 line error, 6 character timeout. They read 0 when nothing is pending.
- R4: When several enabled causes are active, the code follows this priority: line error, then receive data, then character timeout, then transmit space, then modem change.
- R5: Configuration bits gate the causes: bit 0 enables receive data and timeout, bit 1 transmit space, bit 2 line error and bit 3 modem change. A cause with a clear enable bit never makes bit 0 low.
- R6: Status bits 23:16 hold the line byte. Bit 0 is data ready (level), bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break, bit 5 holding register empty (level), bit 6 transmitter idle (level) and bit 7 receive FIFO error. The error bits are sticky until a status read. Any error bit is the line-error cause.
- R7: Status bits 15:8 report the modem byte inverted. Bits 3:0 are change flags and bits 7:4 are levels, each nibble ordered CTS, DSR, RI, DCD from low to high. A change of an input sets its change flag, a status read clears the flags, and any set flag is the modem cause.
- R8: A receive acknowledge strobe clears the pending receive-data and character-timeout causes.
- R9: A configuration write stores bits 3:0 and 29:24 of the write data. All other configuration bits read 0.
- R10: A new source event in the same cycle as its clearing strobe wins: the cause stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| stat_rd | input | 1 | Status read strobe, clears line errors and modem change flags |
| rx_ack | input | 1 | Receive acknowledge strobe, clears receive causes |
| rx_trig | input | 1 | Pulse: receive trigger level reached |
| rx_tmo | input | 1 | Pulse: character timeout |
| tx_space | input | 1 | Level: transmit buffer has room |
| rx_ready | input | 1 | Level: received data present |
| thr_empty | input | 1 | Level: transmit holding register empty |
| tx_idle | input | 1 | Level: transmitter fully idle |
| err_ovr | input | 1 | Pulse: overrun error |
| err_par | input | 1 | Pulse: parity error |
| err_frm | input | 1 | Pulse: framing error |
| err_brk | input | 1 | Pulse: break detected |
| err_fifo | input | 1 | Pulse: receive FIFO error |
| mdm_cts | input | 1 | CTS input level |
| mdm_dsr | input | 1 | DSR input level |
| mdm_ri | input | 1 | RI input level |
| mdm_dcd | input | 1 | DCD input level |
| stat_word | output | 32 | Packed status word |
| cfg_word | output | 32 | Configuration word |
| irq | output | 1 | Interrupt line, high while a cause is pending |

## Verification
The assertions assume that the modem inputs are already synchronous to `clk`. They also assume that software strobes and source pulses change only between edges. The clear checks assume no new event of the same kind arrives in the clearing cycle, because the set-wins rule would then keep the cause. The stimulus drives every input on the falling edge and holds each strobe for one cycle. Between table entries it returns all levels to rest and then issues a combined status read and receive acknowledge, so each entry starts from an empty state.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    ID_MODEM  = 3'd0,
    ID_TXSP   = 3'd1,
    ID_RXDATA = 3'd2,
    ID_LINE   = 3'd3,
    ID_RXTMO  = 3'd6
  } irq_id_e;

  localparam int          WORD_W   = 32;
  localparam logic [31:0] CFG_KEEP = 32'h3F00_000F;

  // Returns {valid, code}; the highest-priority enabled cause wins.
  function automatic logic [3:0] irq_select(input logic [3:0] en,
                                            input logic line_ev,
                                            input logic rx_ev,
                                            input logic tmo_ev,
                                            input logic tx_ev,
                                            input logic mdm_ev);
    logic [3:0] r;
    if (en[2] && line_ev)      r = {1'b1, ID_LINE};
    else if (en[0] && rx_ev)   r = {1'b1, ID_RXDATA};
    else if (en[0] && tmo_ev)  r = {1'b1, ID_RXTMO};
    else if (en[1] && tx_ev)   r = {1'b1, ID_TXSP};
    else if (en[3] && mdm_ev)  r = {1'b1, ID_MODEM};
    else                       r = 4'b0000;
    return r;
  endfunction

  function automatic logic [31:0] pack_status(input logic       pend_n,
                                              input logic [2:0] code,
                                              input logic [7:0] msr_raw,
                                              input logic [7:0] lsr);
    return {8'h00, lsr, ~msr_raw, 4'h0, code, pend_n};
  endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= set[i] | (q[i] & ~clr);
    end
  end
endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_in,
  input  logic         clr,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] delta_q
);
  logic [N-1:0] change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_in;
  end

  assign change = lvl_in ^ lvl_q;

  uart_irq_sticky #(.W(N)) u_delta (
    .clk(clk), .rst_n(rst_n), .set(change), .clr(clr), .q(delta_q)
  );
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [3:0] en,
  input  logic       line_ev,
  input  logic       rx_ev,
  input  logic       tmo_ev,
  input  logic       tx_ev,
  input  logic       mdm_ev,
  output logic       pend_n,
  output logic [2:0] code
);
  logic [3:0] sel;
  assign sel    = irq_select(en, line_ev, rx_ev, tmo_ev, tx_ev, mdm_ev);
  assign pend_n = ~sel[3];
  assign code   = sel[2:0];
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  input  logic        stat_rd,
  input  logic        rx_ack,
  input  logic        rx_trig,
  input  logic        rx_tmo,
  input  logic        tx_space,
  input  logic        rx_ready,
  input  logic        thr_empty,
  input  logic        tx_idle,
  input  logic        err_ovr,
  input  logic        err_par,
  input  logic        err_frm,
  input  logic        err_brk,
  input  logic        err_fifo,
  input  logic        mdm_cts,
  input  logic        mdm_dsr,
  input  logic        mdm_ri,
  input  logic        mdm_dcd,
  output logic [31:0] stat_word,
  output logic [31:0] cfg_word,
  output logic        irq
);
  localparam int N_ERR = 5;
  localparam int N_MDM = 4;
  localparam int N_LVL = 4;

  logic [WORD_W-1:0] cfg_q;
  logic [N_ERR-1:0]  err_q;
  logic [1:0]        rxsrc_q;
  logic [N_LVL-1:0]  lvl_q;
  logic [N_MDM-1:0]  mdm_lvl;
  logic [N_MDM-1:0]  mdm_delta;
  logic [7:0]        lsr_byte;
  logic              pend_n;
  logic [2:0]        code;

  // Named events for the checker.
  logic lsr_clr_ev, rx_clr_ev, line_ev, mdm_ev;
  assign lsr_clr_ev = stat_rd;
  assign rx_clr_ev  = rx_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_wdata & CFG_KEEP;
  end

  // {tx_idle, thr_empty, rx_ready, tx_space}
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= {tx_idle, thr_empty, rx_ready, tx_space};
  end

  // err_q: [0] overrun [1] parity [2] framing [3] break [4] fifo
  uart_irq_sticky #(.W(N_ERR)) u_err (
    .clk(clk), .rst_n(rst_n),
    .set({err_fifo, err_brk, err_frm, err_par, err_ovr}),
    .clr(lsr_clr_ev), .q(err_q)
  );

  // rxsrc_q: [0] data available [1] timeout
  uart_irq_sticky #(.W(2)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .set({rx_tmo, rx_trig}),
    .clr(rx_clr_ev), .q(rxsrc_q)
  );

  uart_irq_modem #(.N(N_MDM)) u_mdm (
    .clk(clk), .rst_n(rst_n),
    .lvl_in({mdm_dcd, mdm_ri, mdm_dsr, mdm_cts}),
    .clr(lsr_clr_ev),
    .lvl_q(mdm_lvl), .delta_q(mdm_delta)
  );

  assign line_ev  = |err_q;
  assign mdm_ev   = |mdm_delta;
  assign lsr_byte = {err_q[4], lvl_q[3], lvl_q[2], err_q[3:0], lvl_q[1]};

  uart_irq_prio u_prio (
    .en(cfg_q[3:0]), .line_ev(line_ev), .rx_ev(rxsrc_q[0]),
    .tmo_ev(rxsrc_q[1]), .tx_ev(lvl_q[0]), .mdm_ev(mdm_ev),
    .pend_n(pend_n), .code(code)
  );

  assign stat_word = pack_status(pend_n, code, {mdm_lvl, mdm_delta}, lsr_byte);
  assign cfg_word  = cfg_q;
  assign irq       = ~pend_n;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stat_rd,
  input logic        rx_ack,
  input logic        rx_trig,
  input logic        rx_tmo,
  input logic [4:0]  err_in,
  input logic [31:0] stat_word,
  input logic [31:0] cfg_word
);
  logic [2:0] id;
  logic [4:0] err_bits;
  assign id       = stat_word[3:1];
  assign err_bits = {stat_word[23], stat_word[20:17]};

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[0] |-> id == 3'd0);                                             // R3
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_word[0] |-> (id == 3'd0 || id == 3'd1 || id == 3'd2 || id == 3'd3 || id == 3'd6)); // R3
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[2] && (|err_bits)) |-> (!stat_word[0] && id == 3'd3));           // R4
  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[3:0] == 4'h0) |-> stat_word[0]);                                // R5
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && err_in == 5'b0) |=> err_bits == 5'b0);                         // R6
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !rx_trig && !rx_tmo) |=> !(!stat_word[0] && (id == 3'd2 || id == 3'd6))); // R8
  AST_CFG_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word & ~32'h3F00_000F) == 32'h0);                                     // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_in) |=> (|err_bits));                                                // R10
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .rx_ack(rx_ack),
  .rx_trig(rx_trig), .rx_tmo(rx_tmo),
  .err_in({err_fifo, err_brk, err_frm, err_par, err_ovr}),
  .stat_word(stat_word), .cfg_word(cfg_word)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, stat_rd = 0, rx_ack = 0, rx_trig = 0, rx_tmo = 0, tx_space = 0;
  logic rx_ready = 0, thr_empty = 0, tx_idle = 0;
  logic err_ovr = 0, err_par = 0, err_frm = 0, err_brk = 0, err_fifo = 0;
  logic mdm_cts = 0, mdm_dsr = 0, mdm_ri = 0, mdm_dcd = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] stat_word, cfg_word;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (.*);

  // {en[3:0], rxd, tmo, txs, lse, mdc, exp_code[2:0], exp_pend_n}
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    13'b1111_10000_010_0, // R3 receive data
    13'b1111_01000_110_0, // R3 timeout
    13'b1111_00100_001_0, // R3 transmit space
    13'b1111_00010_011_0, // R3 line error
    13'b1111_00001_000_0, // R3 modem change
    13'b1111_11111_011_0, // R4 all -> line
    13'b1111_10101_010_0, // R4 data over tx and modem
    13'b1111_01101_110_0, // R4 timeout over tx and modem
    13'b1111_00101_001_0, // R4 tx over modem
    13'b0000_11111_000_1, // R5 all masked
    13'b1011_11111_010_0, // R5 line masked
    13'b1010_11111_001_0, // R5 rx and line masked
    13'b1000_11111_000_0, // R5 modem only
    13'b0001_11000_010_0, // R4 data over timeout
    13'b1111_00000_000_1, // R3 nothing pending
    13'b0100_00010_011_0, // R5 line only
    13'b0100_10101_000_1  // R5 others masked
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] d);
    cfg_wr = 1; cfg_wdata = d; tick(); cfg_wr = 0;
  endtask

  task automatic read_stat();
    stat_rd = 1; tick(); stat_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R1 reset status", stat_word, 32'h0000_FF01);
    check("R1 reset cfg", cfg_word, 32'h0);
    check("R1 reset irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      write_cfg({28'b0, VEC[i][12:9]});
      rx_trig = VEC[i][8]; rx_tmo = VEC[i][7]; tx_space = VEC[i][6];
      err_ovr = VEC[i][5]; mdm_cts = VEC[i][4];
      tick();
      rx_trig = 0; rx_tmo = 0; err_ovr = 0;
      check($sformatf("R3 R4 R5 vector %0d code", i), {28'b0, stat_word[3:0]}, {28'b0, VEC[i][3:0]});
      check($sformatf("R2 vector %0d irq", i), {31'b0, irq}, {31'b0, ~VEC[i][0]});
      tx_space = 0; mdm_cts = 0;
      tick();
      stat_rd = 1; rx_ack = 1; tick(); stat_rd = 0; rx_ack = 0;
    end

    write_cfg(32'hFFFF_FFFF);
    tick();
    check("R9 cfg keep", cfg_word, 32'h3F00_000F);

    rx_ready = 1; err_par = 1; tick(); err_par = 0;
    check("R6 line byte", {24'b0, stat_word[23:16]}, 32'h05);
    check("R6 line code", {28'b0, stat_word[3:0]}, 32'h6);
    read_stat();
    check("R6 after read", {24'b0, stat_word[23:16]}, 32'h01);
    check("R6 pend cleared", {31'b0, stat_word[0]}, 32'h1);
    rx_ready = 0; thr_empty = 1; tx_idle = 1; tick();
    check("R6 levels", {24'b0, stat_word[23:16]}, 32'h60);
    thr_empty = 0; tx_idle = 0;

    stat_rd = 1; err_frm = 1; tick(); stat_rd = 0; err_frm = 0;
    check("R10 error survives read", {24'b0, stat_word[23:16]}, 32'h08);
    read_stat();
    check("R6 framing cleared", {24'b0, stat_word[23:16]}, 32'h00);

    rx_trig = 1; tick(); rx_trig = 0;
    check("R8 data pending", {28'b0, stat_word[3:0]}, 32'h4);
    rx_ack = 1; tick(); rx_ack = 0;
    check("R8 data cleared", {28'b0, stat_word[3:0]}, 32'h1);
    rx_tmo = 1; tick(); rx_tmo = 0;
    check("R8 timeout pending", {28'b0, stat_word[3:0]}, 32'hC);
    rx_ack = 1; rx_trig = 1; tick(); rx_ack = 0; rx_trig = 0;
    check("R10 data survives ack", {28'b0, stat_word[3:0]}, 32'h4);
    rx_ack = 1; tick(); rx_ack = 0;
    check("R8 all rx cleared", {28'b0, stat_word[3:0]}, 32'h1);

    mdm_dcd = 1; tick();
    check("R7 dcd change", {24'b0, stat_word[15:8]}, 32'h77);
    check("R7 modem code", {28'b0, stat_word[3:0]}, 32'h0);
    read_stat();
    check("R7 change cleared", {24'b0, stat_word[15:8]}, 32'h7F);
    check("R2 irq low", {31'b0, irq}, 32'h0);
    mdm_dcd = 0; tick(); read_stat();
    check("R7 back to rest", {24'b0, stat_word[15:8]}, 32'hFF);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule